// File: doc/BRIEF.md
# Ready-Wait Status Poller

After a command has been sent to a serial NAND flash device, this block waits for the device to report that it is ready. A start pulse and an operation type begin the wait. The block lets an initial delay pass and then requests a status-register read. While the returned byte shows the device busy, it waits a shorter poll interval and asks again. Both delays depend on the operation type and are counted in microsecond ticks. Another block on the device bus carries out each status read and hands back the byte with a valid strobe.

A global timeout, also counted in ticks from the start, bounds the whole wait. When the timeout is reached, the block does not wait for the current interval to run out. It asks for one last status read at once, and it reports a timeout only if that read still shows busy. At the end of the wait the block gives a one-cycle done pulse and holds the last status byte and its decoded outcome until the next wait finishes.

Top module: `nand_ready_poller`

## Requirements
- R1: After reset, busy, the status request, done and timeout are all low, and the held status byte is 0x00.
- R2: The first status request rises on the cycle after the Nth microsecond tick that follows the start pulse. N is selected by the operation code: 0 (page read) gives 6, 1 (program) gives 75, 2 (erase) gives 250 and 3 (reset) gives 5.
- R3: After a status byte with bit 0 set (busy), the next request follows after M further ticks. M is 5 for code 0, 15 for code 1, 50 for code 2 and 5 for code 3.
- R4: The status request stays high until a valid strobe arrives. A valid byte with bit 0 clear ends the wait: done pulses, busy falls, and the byte appears on the status output.
- R5: Status bit 2 drives the erase-failure flag, bit 3 drives the program-failure flag, and bits [5:4] drive the ECC outcome (00 clean, 01 corrected, 10 uncorrectable).
- R6: When the tick count since start reaches TIMEOUT_US, a status request is issued with no further delay. If that read shows busy, the wait ends with done and the timeout flag high, and the busy byte is held.
- R7: If the read issued at the timeout shows ready, the wait ends normally and the timeout flag is low.
- R8: A start pulse during a wait is ignored. The operation and the interval lengths do not change.
- R9: Busy and done are never high together, and done lasts exactly one cycle.
- R10: A valid strobe while no request is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a wait (single-cycle pulse) |
| op_i | input | 2 | Operation code: 0 read, 1 program, 2 erase, 3 reset |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| stat_req_o | output | 1 | Status-register read request |
| stat_valid_i | input | 1 | Status byte valid strobe |
| stat_byte_i | input | 8 | Returned status byte |
| busy_o | output | 1 | A wait is in progress |
| done_o | output | 1 | One-cycle pulse when the wait ends |
| timeout_o | output | 1 | The last wait ended by timeout |
| status_o | output | 8 | Last status byte accepted at the end of a wait |
| erase_fail_o | output | 1 | Erase failure flag |
| prog_fail_o | output | 1 | Program failure flag |
| ecc_o | output | 2 | ECC outcome |

## Verification
The bound checker watches every cycle for the following:
- busy and done are never high together, and done lasts one cycle;
- a request is only raised during a wait, and it drops once a byte is accepted;
- a wait survives any cycle without a strobe, whatever arrives on start;
- the held status byte and the timeout flag change only together with done.

Only the bench scenarios can show the rest:
- the exact tick counts of each operation's first delay and poll interval;
- the read taken at the timeout instant and the two ways it can end;
- that a stray start or strobe leaves the interval length unchanged.

// File: rtl/nand_ready_poller.sv
module nand_ready_poller #(
  parameter int RD_INIT_US = 6,
  parameter int RD_POLL_US = 5,
  parameter int PG_INIT_US = 75,
  parameter int PG_POLL_US = 15,
  parameter int ER_INIT_US = 250,
  parameter int ER_POLL_US = 50,
  parameter int RS_INIT_US = 5,
  parameter int RS_POLL_US = 5,
  parameter int TIMEOUT_US = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       us_tick_i,
  output logic       stat_req_o,
  input  logic       stat_valid_i,
  input  logic [7:0] stat_byte_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o,
  output logic [7:0] status_o,
  output logic       erase_fail_o,
  output logic       prog_fail_o,
  output logic [1:0] ecc_o
);
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int DLY_MAX = mx(mx(mx(RD_INIT_US, RD_POLL_US), mx(PG_INIT_US, PG_POLL_US)),
                              mx(mx(ER_INIT_US, ER_POLL_US), mx(RS_INIT_US, RS_POLL_US)));
  localparam int DW = $clog2(DLY_MAX + 1);
  localparam int TW = $clog2(TIMEOUT_US + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_REQ} st_t;

  st_t           st;
  logic [1:0]    op_q;
  logic [DW-1:0] dly, init_dly, poll_dly;
  logic [TW-1:0] tmo;
  logic          expired;

  always_comb begin
    case (op_i)
      2'd0:    init_dly = DW'(RD_INIT_US);
      2'd1:    init_dly = DW'(PG_INIT_US);
      2'd2:    init_dly = DW'(ER_INIT_US);
      default: init_dly = DW'(RS_INIT_US);
    endcase
    case (op_q)
      2'd0:    poll_dly = DW'(RD_POLL_US);
      2'd1:    poll_dly = DW'(PG_POLL_US);
      2'd2:    poll_dly = DW'(ER_POLL_US);
      default: poll_dly = DW'(RS_POLL_US);
    endcase
  end

  assign expired      = (tmo == TW'(TIMEOUT_US));
  assign busy_o       = (st != S_IDLE);
  assign stat_req_o   = (st == S_REQ);
  assign erase_fail_o = status_o[2];
  assign prog_fail_o  = status_o[3];
  assign ecc_o        = status_o[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= '0;
      dly       <= '0;
      tmo       <= '0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      status_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          op_q <= op_i;
          dly  <= init_dly;
          tmo  <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if ((us_tick_i && dly <= DW'(1)) || expired) st <= S_REQ;
          else if (us_tick_i)                          dly <= dly - DW'(1);
        end
        S_REQ: if (stat_valid_i) begin
          if (!stat_byte_i[0] || expired) begin
            st        <= S_IDLE;
            done_o    <= 1'b1;
            status_o  <= stat_byte_i;
            timeout_o <= stat_byte_i[0];
          end else begin
            dly <= poll_dly;
            st  <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (st != S_IDLE && us_tick_i && !expired) tmo <= tmo + TW'(1);
    end
  end
endmodule

// File: rtl/nand_ready_poller_chk.sv
module nand_ready_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       stat_req_o,
  input logic       stat_valid_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       timeout_o,
  input logic [7:0] status_o
);
  a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r4_req_inside_wait: assert property (@(posedge clk) disable iff (!rst_n)
    stat_req_o |-> busy_o);
  a_r4_req_drops_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_req_o && stat_valid_i) |=> !stat_req_o);
  a_r8_wait_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !stat_valid_i) |=> busy_o);
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !stat_req_o) |=> busy_o && !done_o);
  a_r6_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timeout_o) |-> done_o);
  a_r4_status_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o) |-> done_o);
endmodule

bind nand_ready_poller nand_ready_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stat_req_o(stat_req_o),
  .stat_valid_i(stat_valid_i), .busy_o(busy_o), .done_o(done_o),
  .timeout_o(timeout_o), .status_o(status_o)
);

// File: tb/test_nand_ready_poller.sv
module test_nand_ready_poller;
  localparam int TMO = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = '0;
  logic       us_tick_i = 1'b0;
  logic       stat_valid_i = 1'b0;
  logic [7:0] stat_byte_i = '0;
  logic       stat_req_o, busy_o, done_o, timeout_o, erase_fail_o, prog_fail_o;
  logic [7:0] status_o;
  logic [1:0] ecc_o;

  int checks = 0;
  int fails  = 0;

  nand_ready_poller #(.TIMEOUT_US(TMO)) i_nand_ready_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .us_tick_i(us_tick_i),
    .stat_req_o(stat_req_o), .stat_valid_i(stat_valid_i), .stat_byte_i(stat_byte_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .status_o(status_o),
    .erase_fail_o(erase_fail_o), .prog_fail_o(prog_fail_o), .ecc_o(ecc_o)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk);
    #2 us_tick_i = ~us_tick_i;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // {op[1:0], busy_reads[3:0], final_byte[7:0]}
  localparam logic [13:0] VEC [7] = '{
    {2'd0, 4'd0, 8'h00}, {2'd0, 4'd2, 8'h10}, {2'd1, 4'd1, 8'h08},
    {2'd2, 4'd2, 8'h04}, {2'd3, 4'd3, 8'h00}, {2'd0, 4'd1, 8'h20},
    {2'd1, 4'd0, 8'h30}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_init(input int op);
    case (op) 0: return 6; 1: return 75; 2: return 250; default: return 5; endcase
  endfunction

  function automatic int exp_poll(input int op);
    case (op) 0: return 5; 1: return 15; 2: return 50; default: return 5; endcase
  endfunction

  task automatic kick(input logic [1:0] op);
    @(negedge clk);
    op_i = op;
    start_i = 1'b1;
  endtask

  task automatic wait_req(input bit inject, input bit spurious, output int n);
    n = 0;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      stat_valid_i = 1'b0;
      start_i = 1'b0;
      if (stat_req_o) return;
      if (us_tick_i && busy_o) n++;
      if (inject && i == 0) begin start_i = 1'b1; op_i = 2'd2; end
      if (spurious && i == 0) begin stat_valid_i = 1'b1; stat_byte_i = 8'h00; end
    end
  endtask

  task automatic respond(input logic [7:0] b);
    stat_byte_i = b;
    stat_valid_i = 1'b1;
  endtask

  task automatic check_end(input logic [7:0] fin, input bit tmo_exp);
    @(negedge clk);
    stat_valid_i = 1'b0;
    chk(done_o === 1'b1, "R4 done pulse", done_o, 1);
    chk(busy_o === 1'b0, "R9 busy low with done", busy_o, 0);
    chk(status_o === fin, "R4 status held", status_o, fin);
    chk(erase_fail_o === fin[2], "R5 erase flag", erase_fail_o, fin[2]);
    chk(prog_fail_o === fin[3], "R5 program flag", prog_fail_o, fin[3]);
    chk(ecc_o === fin[5:4], "R5 ecc field", ecc_o, fin[5:4]);
    chk(timeout_o === tmo_exp, tmo_exp ? "R6 timeout set" : "R7 timeout clear", timeout_o, tmo_exp);
    @(negedge clk);
    chk(done_o === 1'b0, "R9 done one cycle", done_o, 0);
  endtask

  initial begin
    int n, total;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && stat_req_o === 1'b0 && done_o === 1'b0, "R1 reset controls", busy_o, 0);
    chk(timeout_o === 1'b0 && status_o === 8'h00, "R1 reset status", status_o, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 7; v++) begin
      int op, nb;
      logic [7:0] fin;
      op = int'(VEC[v][13:12]);
      nb = int'(VEC[v][11:8]);
      fin = VEC[v][7:0];
      kick(VEC[v][13:12]);
      for (int r = 0; r <= nb; r++) begin
        wait_req(1'b0, 1'b0, n);
        if (r == 0) chk(n == exp_init(op), "R2 initial delay", n, exp_init(op));
        else        chk(n == exp_poll(op), "R3 poll interval", n, exp_poll(op));
        respond((r < nb) ? 8'h3D : fin);
      end
      check_end(fin, 1'b0);
    end

    // R8: start during a read wait is ignored
    kick(2'd0);
    wait_req(1'b0, 1'b0, n);
    chk(n == 6, "R8 initial before stray start", n, 6);
    respond(8'h01);
    wait_req(1'b1, 1'b0, n);
    chk(n == 5, "R8 poll kept after stray start", n, 5);
    respond(8'h00);
    check_end(8'h00, 1'b0);

    // R10: strobe with no pending request
    kick(2'd3);
    wait_req(1'b0, 1'b1, n);
    chk(n == 5, "R10 stray strobe ignored", n, 5);
    respond(8'h00);
    check_end(8'h00, 1'b0);

    // R6: timeout with device still busy
    kick(2'd1);
    total = 0;
    for (int r = 0; r < 100; r++) begin
      wait_req(1'b0, 1'b0, n);
      total += n;
      if (total >= TMO) break;
      respond(8'h3D);
    end
    chk(total == TMO, "R6 final read at timeout", total, TMO);
    respond(8'h3D);
    check_end(8'h3D, 1'b1);

    // R7: final read shows ready
    kick(2'd1);
    total = 0;
    for (int r = 0; r < 100; r++) begin
      wait_req(1'b0, 1'b0, n);
      total += n;
      if (total >= TMO) break;
      respond(8'h3D);
    end
    chk(total == TMO, "R7 final read at timeout", total, TMO);
    respond(8'h00);
    check_end(8'h00, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule